// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Engine

This block is the read half of a two-wire serial EEPROM slave with a 256-byte array. It samples the clock and data lines against a fast system clock and watches for start and stop conditions. It acknowledges its own device address byte. It then returns data from an internal byte array, sending the most significant bit first.

A master can read from the current position of the internal address pointer. It can also read from any location: it first sends the word address in a write that carries no data, then issues a repeated start and a read command. Each time the master acknowledges a byte, the engine sends the byte at the next address. Because of this, one read command can stream the whole array, and the pointer wraps from the top address back to zero. The transfer ends when the master leaves the ninth-clock acknowledge high and then issues a stop. The pointer keeps its value across transfers. A side load port fills the array before the bus is used.

Top module: `eeprom_seq_reader`

## Requirements
- R1: A stop condition (data rising while clock high) returns the engine to idle with SDA released. A start condition (data falling while clock high) restarts byte reception from bit zero, even in the middle of a byte.
- R2: The address byte is decoded as bits 7..4 = 1010, bits 3..1 = `dev_sel_i` and bit 0 = direction (1 = read). Only a matching byte is acknowledged, by holding SDA low through the ninth clock. After a mismatch, SDA stays high until the next start.
- R3: In a write command, the byte after the address byte is taken as the word address and loads the pointer. A repeated start followed by a read command then returns the byte stored at that address.
- R4: A read command that has no word-address phase returns the byte at the current pointer value.
- R5: Data bits go out most significant bit first, and `sda_o` changes only while SCL is low.
- R6: When the master acknowledges a data byte, the next byte sent is the one at the following address. `sda_o` is high (released) during every master acknowledge bit.
- R7: When the pointer passes address 255 it wraps to 0 within the same transfer.
- R8: A master non-acknowledge ends the data stream. The pointer holds last-read address + 1 across the stop, so a later current-address read continues from there.
- R9: A single read command can return all 256 bytes in order and then continue past the wrap.
- R10: A write on the load port (`ld_en_i` high) stores `ld_data_i` at `ld_addr_i`, and that value is the one later read over the bus.
- R11: While reset is asserted and after it is released, `sda_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| dev_sel_i | input | 3 | Device-select bits compared with address bits 3..1 |
| ld_en_i | input | 1 | Array load strobe |
| ld_addr_i | input | AW | Array load address |
| ld_data_i | input | 8 | Array load data |
| sda_o | output | 1 | Data line drive: 0 pulls low, 1 releases |

## Verification
The embedded properties are checked on every cycle. They cover the following: an address acknowledge only ever follows a matching address byte; `sda_o` moves only after a low clock sample; the line stays released in the master acknowledge slot; a stop always leaves the engine idle and released; a start always clears the bit count; and the pointer goes from 255 to 0 when it advances. Some behaviour can only be shown by the bench scenarios, because it depends on array contents and on history across transfers. This includes the data values returned in random, current-address and full-array streams, the pointer being kept across a stop, a start that aborts a byte in progress, and load-port contents appearing on the bus.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WADDR,
        ST_ACK_WADDR,
        ST_HOLD,
        ST_TX,
        ST_MACK
    } rd_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // bit 1 = clock line, bit 0 = data line
    typedef struct packed {
        logic [1:0] m1;
        logic [1:0] m2;
        logic [1:0] pv;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.m1 = {scl_i, sda_i};
        s_d.m2 = s_q.m1;
        s_d.pv = s_q.m2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{m1: 2'b11, m2: 2'b11, pv: 2'b11};
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.m2[1];
    assign sda_s     = s_q.m2[0];
    assign scl_rise  =  s_q.m2[1] & ~s_q.pv[1];
    assign scl_fall  = ~s_q.m2[1] &  s_q.pv[1];
    assign start_det =  s_q.m2[1] &  s_q.pv[1] &  s_q.pv[0] & ~s_q.m2[0];
    assign stop_det  =  s_q.m2[1] &  s_q.pv[1] & ~s_q.pv[0] &  s_q.m2[0];
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int AW = 8
) (
    input  logic                              clk,
    input  logic                              ld_en_i,
    input  logic [AW-1:0]                     ld_addr_i,
    input  logic [eeprom_rd_pkg::BYTE_W-1:0]  ld_data_i,
    input  logic [AW-1:0]                     rd_addr_i,
    output logic [eeprom_rd_pkg::BYTE_W-1:0]  rd_data_o
);
    localparam int DEPTH = 1 << AW;

    logic [eeprom_rd_pkg::BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en_i) mem_q[ld_addr_i] <= ld_data_i;
    end

    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader #(
    parameter int         AW       = 8,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    dev_sel_i,
    input  logic          ld_en_i,
    input  logic [AW-1:0] ld_addr_i,
    input  logic [7:0]    ld_data_i,
    output logic          sda_o
);
    import eeprom_rd_pkg::*;

    localparam logic [AW-1:0] PTR_MAX = {AW{1'b1}};
    localparam logic [2:0]    LAST_BIT = 3'(BYTE_W - 1);

    typedef struct packed {
        rd_state_e         st;
        logic [2:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [AW-1:0]     ptr;
        logic              sda;
        logic              rw;
        logic              flag;
    } core_t;

    core_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rd_data;
    logic fetch;

    line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    byte_store #(.AW(AW)) u_store (
        .clk       (clk),
        .ld_en_i   (ld_en_i),
        .ld_addr_i (ld_addr_i),
        .ld_data_i (ld_data_i),
        .rd_addr_i (r_q.ptr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        r_d   = r_q;
        fetch = 1'b0;
        if (stop_det) begin
            r_d.st   = ST_IDLE;
            r_d.sda  = 1'b1;
            r_d.cnt  = '0;
            r_d.flag = 1'b0;
        end else if (start_det) begin
            r_d.st   = ST_DEV;
            r_d.sda  = 1'b1;
            r_d.cnt  = '0;
            r_d.flag = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_DEV, ST_WADDR: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 3'd1;
                        if (r_q.cnt == LAST_BIT) r_d.flag = 1'b1;
                    end else if (scl_fall && r_q.flag) begin
                        r_d.flag = 1'b0;
                        if (r_q.st == ST_DEV) begin
                            if (r_q.sh[7:1] == {DEV_CODE, dev_sel_i}) begin
                                r_d.st  = ST_ACK_DEV;
                                r_d.sda = 1'b0;
                                r_d.rw  = r_q.sh[0];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else begin
                            r_d.ptr = r_q.sh[AW-1:0];
                            r_d.st  = ST_ACK_WADDR;
                            r_d.sda = 1'b0;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            fetch   = 1'b1;
                            r_d.st  = ST_TX;
                            r_d.sh  = rd_data;
                            r_d.sda = rd_data[BYTE_W-1];
                            r_d.ptr = r_q.ptr + 1'b1;
                        end else begin
                            r_d.st  = ST_WADDR;
                            r_d.sda = 1'b1;
                        end
                    end
                end
                ST_ACK_WADDR: begin
                    if (scl_fall) begin
                        r_d.st  = ST_HOLD;
                        r_d.sda = 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.st  = ST_MACK;
                            r_d.sda = 1'b1;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = r_q.cnt + 3'd1;
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.sda = r_q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) r_d.st   = ST_IDLE;
                        else       r_d.flag = 1'b1;
                    end else if (scl_fall && r_q.flag) begin
                        fetch    = 1'b1;
                        r_d.flag = 1'b0;
                        r_d.st   = ST_TX;
                        r_d.sh   = rd_data;
                        r_d.sda  = rd_data[BYTE_W-1];
                        r_d.cnt  = '0;
                        r_d.ptr  = r_q.ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0,
                     sda: 1'b1, rw: 1'b0, flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_o = r_q.sda;

    // R2: an address acknowledge is only held for a matching address byte
    p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK_DEV) |-> (r_q.sh[7:1] == {DEV_CODE, dev_sel_i}));

    // R5: the data drive moves only after the clock was sampled low
    p_sda_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.sda) |-> !$past(scl_s));

    // R6: the line is released while the master acknowledges
    p_mack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MACK) |-> r_q.sda);

    // R7: the pointer wraps from its top value to zero
    p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fetch) && ($past(r_q.ptr) == PTR_MAX)) |-> (r_q.ptr == '0));

    // R1: a stop leaves the engine idle with the line released
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> ((r_q.st == ST_IDLE) && r_q.sda));

    // R1: a start restarts reception from bit zero
    p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> ((r_q.st == ST_DEV) && (r_q.cnt == 3'd0)));
endmodule

// File: tb/eeprom_seq_reader_tb.sv
`timescale 1ns/1ps
module eeprom_seq_reader_tb;
    localparam int AW = 8;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic dut_sda;
    logic sda_line;
    logic prev_sda = 1'b1;
    int checks = 0;
    int failures = 0;
    int r5_viol = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & dut_sda;

    eeprom_seq_reader #(.AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .dev_sel_i (SEL),
        .ld_en_i   (ld_en),
        .ld_addr_i (ld_addr),
        .ld_data_i (ld_data),
        .sda_o     (dut_sda)
    );

    // R5 monitor: slave drive must not move while the clock line is high
    always @(posedge clk) begin
        if (rst_n && scl_m && (dut_sda != prev_sda)) r5_viol++;
        prev_sda <= dut_sda;
    end

    function automatic logic [7:0] pat(input int i);
        return 8'(((i & 255) * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(4);
        scl_m = 1'b1; wt(4);
        sda_m = 1'b0; wt(4);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(4);
        scl_m = 1'b1; wt(4);
        sda_m = 1'b1; wt(8);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wt(4);
        scl_m = 1'b1; wt(8);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wt(4);
        scl_m = 1'b1; wt(4);
        ack = (sda_line == 1'b0);
        wt(4);
        scl_m = 1'b0; wt(4);
    endtask

    task automatic read_byte(input bit do_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(4);
            scl_m = 1'b1; wt(4);
            b[i] = sda_line; wt(4);
            scl_m = 1'b0;
        end
        wt(4);
        sda_m = do_ack ? 1'b0 : 1'b1; wt(4);
        scl_m = 1'b1; wt(4);
        if (do_ack) chk(dut_sda == 1'b1, "R6 release in master ack", dut_sda, 1);
        wt(4);
        scl_m = 1'b0; wt(4);
        sda_m = 1'b1;
    endtask

    task automatic random_read(input int addr, input int n, input string req);
        bit ack;
        logic [7:0] b;
        int bad = 0;
        int first_bad_a = 0;
        int first_bad_e = 0;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ack);
        chk(ack, "R2 write address ack", ack, 1);
        send_byte(8'(addr), ack);
        chk(ack, "R3 word address ack", ack, 1);
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k < n - 1, b);
            if (b != pat(addr + k)) begin
                if (bad == 0) begin first_bad_a = b; first_bad_e = pat(addr + k); end
                bad++;
            end
        end
        bus_stop();
        chk(bad == 0, req, first_bad_a, first_bad_e);
    endtask

    task automatic current_read(input int exp_addr, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, SEL, 1'b1}, ack);
        chk(ack, "R4 read address ack", ack, 1);
        read_byte(1'b0, b);
        bus_stop();
        chk(b == pat(exp_addr), req, b, pat(exp_addr));
    endtask

    task automatic t_reset();
        wt(10);
        chk(dut_sda == 1'b1, "R11 sda in reset", dut_sda, 1);
        rst_n = 1'b1;
        wt(10);
        chk(dut_sda == 1'b1, "R11 sda after reset", dut_sda, 1);
    endtask

    task automatic t_preload();
        for (int i = 0; i < 256; i++) begin
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = pat(i);
            wt(1);
        end
        ld_en = 1'b0;
        wt(4);
    endtask

    task automatic t_mismatch();
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b1}, ack);
        chk(!ack, "R2 no ack on mismatch", ack, 0);
        read_byte(1'b0, b);
        chk(b == 8'hFF, "R2 silent after mismatch", b, 8'hFF);
        bus_stop();
        chk(dut_sda == 1'b1, "R1 released after stop", dut_sda, 1);
    endtask

    task automatic t_abort();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        random_read(100, 1, "R1 start mid-byte then read");
    endtask

    initial begin
        sda_m = 1'b1; scl_m = 1'b1;
        t_reset();
        t_preload();
        t_mismatch();
        random_read(10, 1, "R3 R10 random read");
        current_read(11, "R4 R8 current read after nack");
        current_read(12, "R8 pointer kept across stop");
        random_read(253, 5, "R6 R7 stream across wrap");
        current_read(2, "R7 pointer after wrap");
        bus_start();
        t_abort();
        random_read(64, 257, "R9 full array stream");
        current_read(65, "R8 R9 pointer after full stream");
        chk(r5_viol == 0, "R5 sda stable while scl high", r5_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule